// File: doc/BRIEF.md
# Trap Entry and Return Context Sequencer

This block is the hardware half of exception handling for a small 16-bit accumulator processor. When the decoder presents an instruction whose opcode is one of the reserved, unimplemented values, the sequencer takes over the memory port. It fetches the system-stack base from a hard-wired vector and saves the instruction specifier and the full register context on that stack. It then fetches the handler entry address from a second hard-wired vector and loads the stack pointer and the program counter so that the next fetch is the first handler instruction.

On a return request the sequencer reads the saved frame back from the current stack pointer and reloads the flags, accumulator, index, base, program counter and stack pointer in that order. The saved instruction specifier stays in memory and is skipped. The processor core stalls while `busy` is high and keeps its registers stable on the observe ports. The sequencer changes them only through the one-cycle load strobes that share the `ld_word` bus.

Top module: `trap_ctx_seq`

## Requirements
- R1: With the sequencer idle, a cycle with `instr_valid` high and `ir[7:3]` equal to 5'b11101, 5'b11110 or 5'b11111 starts an entry sequence, so `busy` is high from the next cycle on. Any other opcode leaves `busy` low, writes no memory and loads no register.
- R2: The entry sequence reads the system-stack base from byte addresses 0x0FFA (high byte) and 0x0FFB (low byte). It reads the handler address from 0x0FFE (high byte) and 0x0FFF (low byte).
- R3: Starting at stack base S, entry writes 12 bytes at strictly falling addresses S-1 down to S-12, one per cycle. The bytes are: the instruction specifier at S-1; then SP, PC, B, X and A, each stored with its high byte at the lower address (SP at S-3/S-2, PC at S-5/S-4, B at S-7/S-6, X at S-9/S-8, A at S-11/S-10); and finally the flags, zero-extended in bits 3:0, at S-12.
- R4: An entry sequence keeps `busy` high for exactly 16 cycles. It ends with SP = S-12 and PC = the handler address, and A, X, B and the flags are unchanged.
- R5: A return sequence reads 11 bytes upward from the current SP and keeps `busy` high for exactly 11 cycles. It loads the flags, A, X, B, PC and SP in that order, taking their values from memory. The instruction-specifier byte is never read.
- R6: A trap followed by a return, with the frame left untouched, restores every register to its value before the trap.
- R7: A trap or return request that arrives while `busy` is high is ignored. When a trap and a return request arrive together in the idle state, the trap wins.
- R8: Memory strobes and register load strobes are active only while `busy` is high. A read and a write are never issued in the same cycle, and at most one load strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented on `ir` |
| ir | input | 8 | Instruction specifier, opcode in bits 7:3 |
| rti_req | input | 1 | Request to run the return sequence |
| busy | output | 1 | A sequence is running; the core stalls |
| mem_addr | output | 16 | Byte address |
| mem_re | output | 1 | Read strobe, data returned in the same cycle |
| mem_we | output | 1 | Write strobe, byte written at the clock edge |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| cur_a | input | 16 | Accumulator value |
| cur_x | input | 16 | Index register value |
| cur_b | input | 16 | Base register value |
| cur_sp | input | 16 | Stack pointer value |
| cur_pc | input | 16 | Program counter value |
| cur_flags | input | 4 | Condition flags |
| ld_a | output | 1 | Load `ld_word` into A |
| ld_x | output | 1 | Load `ld_word` into X |
| ld_b | output | 1 | Load `ld_word` into B |
| ld_sp | output | 1 | Load `ld_word` into SP |
| ld_pc | output | 1 | Load `ld_word` into PC |
| ld_flags | output | 1 | Load `ld_word[3:0]` into the flags |
| ld_word | output | 16 | Value for the active load strobe |

## Verification
The bench builds the block with its default parameters: stack vector 0x0FFA, handler vector 0x0FFE, and a trapping range of three opcodes starting at 5'b11101. With these values, the three reserved opcodes and their nearest neighbour 5'b11100 can all be driven. The vectors and a full frame also fit in a 4 KiB model memory, so the exact frame image and the stack-pointer arithmetic can be checked byte for byte. Several register patterns are used, along with a frame edited between entry and return and requests injected mid-sequence.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int FLAG_W     = 4;
    localparam int OPC_W      = 5;
    localparam int N_WORD_REG = 5;                       // SP, PC, B, X, A
    localparam int PUSH_BYTES = 2 + 2 * N_WORD_REG;      // spec + words + flags
    localparam int POP_BYTES  = PUSH_BYTES - 1;          // spec is skipped
    localparam int ENTRY_STEPS = PUSH_BYTES + 4;         // 2 base reads, 2 handler reads
    localparam int STEP_W     = $clog2(ENTRY_STEPS);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ENTRY,
        SEQ_RETURN
    } seq_mode_e;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_FLAGS,
        REG_A,
        REG_X,
        REG_B,
        REG_PC,
        REG_SP
    } ctx_reg_e;

    typedef struct packed {
        seq_mode_e           mode;
        logic [STEP_W-1:0]   step;
        logic [WORD_W-1:0]   ptr;
        logic [BYTE_W-1:0]   hold;
    } seq_state_t;
endpackage

// File: rtl/trap_opc_decode.sv
module trap_opc_decode
    import trap_seq_pkg::*;
#(
    parameter logic [OPC_W-1:0] FIRST_TRAP_OPC = 5'b11101,
    parameter int               N_TRAP_OPC     = 3
) (
    input  logic [OPC_W-1:0] opc,
    output logic             is_trap
);
    logic [N_TRAP_OPC-1:0] hit;

    for (genvar i = 0; i < N_TRAP_OPC; i++) begin : g_cmp
        localparam logic [OPC_W-1:0] CODE = FIRST_TRAP_OPC + OPC_W'(i);
        assign hit[i] = (opc == CODE);
    end

    assign is_trap = |hit;
endmodule

// File: rtl/trap_push_mux.sv
module trap_push_mux
    import trap_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    input  logic [BYTE_W-1:0] spec,
    input  logic [WORD_W-1:0] sp_w,
    input  logic [WORD_W-1:0] pc_w,
    input  logic [WORD_W-1:0] b_w,
    input  logic [WORD_W-1:0] x_w,
    input  logic [WORD_W-1:0] a_w,
    input  logic [FLAG_W-1:0] flags,
    output logic [BYTE_W-1:0] byte_o
);
    logic [STEP_W-1:0] rel;
    logic [WORD_W-1:0] word_sel;

    always_comb begin
        rel = idx - STEP_W'(1);
        unique case (rel[STEP_W-1:1])
            0:       word_sel = sp_w;
            1:       word_sel = pc_w;
            2:       word_sel = b_w;
            3:       word_sel = x_w;
            default: word_sel = a_w;
        endcase
        if (idx == '0) begin
            byte_o = spec;
        end else if (idx == STEP_W'(PUSH_BYTES - 1)) begin
            byte_o = {{(BYTE_W-FLAG_W){1'b0}}, flags};
        end else if (rel[0]) begin
            byte_o = word_sel[WORD_W-1:BYTE_W];   // second write, lower address
        end else begin
            byte_o = word_sel[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/trap_pop_route.sv
module trap_pop_route
    import trap_seq_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output ctx_reg_e          target,
    output logic              take_high
);
    always_comb begin
        target    = REG_NONE;
        take_high = 1'b0;
        if (idx == '0) begin
            target = REG_FLAGS;
        end else if (idx[0]) begin
            take_high = 1'b1;
        end else begin
            unique case (idx[STEP_W-1:1])
                1:       target = REG_A;
                2:       target = REG_X;
                3:       target = REG_B;
                4:       target = REG_PC;
                5:       target = REG_SP;
                default: target = REG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/trap_ctx_seq.sv
module trap_ctx_seq
    import trap_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] STACK_VEC      = 16'h0FFA,
    parameter logic [WORD_W-1:0] HANDLER_VEC    = 16'h0FFE,
    parameter logic [OPC_W-1:0]  FIRST_TRAP_OPC = 5'b11101,
    parameter int                N_TRAP_OPC     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [BYTE_W-1:0] ir,
    input  logic              rti_req,
    output logic              busy,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] cur_a,
    input  logic [WORD_W-1:0] cur_x,
    input  logic [WORD_W-1:0] cur_b,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] cur_pc,
    input  logic [FLAG_W-1:0] cur_flags,
    output logic              ld_a,
    output logic              ld_x,
    output logic              ld_b,
    output logic              ld_sp,
    output logic              ld_pc,
    output logic              ld_flags,
    output logic [WORD_W-1:0] ld_word
);
    localparam logic [STEP_W-1:0] LAST_PUSH_STEP = STEP_W'(PUSH_BYTES + 1);
    localparam logic [STEP_W-1:0] SP_LOAD_STEP   = STEP_W'(PUSH_BYTES + 2);
    localparam logic [STEP_W-1:0] LAST_POP_STEP  = STEP_W'(POP_BYTES - 1);

    seq_state_t         cur_q, nxt_d;
    logic               is_trap;
    logic [BYTE_W-1:0]  push_byte;
    ctx_reg_e           pop_tgt;
    logic               pop_high;
    ctx_reg_e           tgt;

    trap_opc_decode #(
        .FIRST_TRAP_OPC (FIRST_TRAP_OPC),
        .N_TRAP_OPC     (N_TRAP_OPC)
    ) u_dec (
        .opc     (ir[BYTE_W-1 -: OPC_W]),
        .is_trap (is_trap)
    );

    trap_push_mux u_push (
        .idx    (cur_q.step - STEP_W'(2)),
        .spec   (ir),
        .sp_w   (cur_sp),
        .pc_w   (cur_pc),
        .b_w    (cur_b),
        .x_w    (cur_x),
        .a_w    (cur_a),
        .flags  (cur_flags),
        .byte_o (push_byte)
    );

    trap_pop_route u_pop (
        .idx       (cur_q.step),
        .target    (pop_tgt),
        .take_high (pop_high)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tgt       = REG_NONE;
        ld_word   = '0;
        unique case (cur_q.mode)
            SEQ_IDLE: begin
                if (instr_valid && is_trap) begin
                    nxt_d.mode = SEQ_ENTRY;
                    nxt_d.step = '0;
                end else if (rti_req) begin
                    nxt_d.mode = SEQ_RETURN;
                    nxt_d.step = '0;
                    nxt_d.ptr  = cur_sp;
                end
            end
            SEQ_ENTRY: begin
                nxt_d.step = cur_q.step + STEP_W'(1);
                if (cur_q.step == '0) begin
                    mem_re     = 1'b1;
                    mem_addr   = STACK_VEC;
                    nxt_d.hold = mem_rdata;
                end else if (cur_q.step == STEP_W'(1)) begin
                    mem_re    = 1'b1;
                    mem_addr  = STACK_VEC + WORD_W'(1);
                    nxt_d.ptr = {cur_q.hold, mem_rdata};
                end else if (cur_q.step <= LAST_PUSH_STEP) begin
                    mem_we    = 1'b1;
                    mem_addr  = cur_q.ptr - WORD_W'(1);
                    mem_wdata = push_byte;
                    nxt_d.ptr = cur_q.ptr - WORD_W'(1);
                end else if (cur_q.step == SP_LOAD_STEP) begin
                    mem_re     = 1'b1;
                    mem_addr   = HANDLER_VEC;
                    nxt_d.hold = mem_rdata;
                    tgt        = REG_SP;
                    ld_word    = cur_q.ptr;
                end else begin
                    mem_re     = 1'b1;
                    mem_addr   = HANDLER_VEC + WORD_W'(1);
                    tgt        = REG_PC;
                    ld_word    = {cur_q.hold, mem_rdata};
                    nxt_d.mode = SEQ_IDLE;
                    nxt_d.step = '0;
                end
            end
            SEQ_RETURN: begin
                mem_re     = 1'b1;
                mem_addr   = cur_q.ptr;
                nxt_d.ptr  = cur_q.ptr + WORD_W'(1);
                nxt_d.step = cur_q.step + STEP_W'(1);
                if (pop_high) begin
                    nxt_d.hold = mem_rdata;
                end
                tgt = pop_tgt;
                if (pop_tgt == REG_FLAGS) begin
                    ld_word = {{(WORD_W-FLAG_W){1'b0}}, mem_rdata[FLAG_W-1:0]};
                end else begin
                    ld_word = {cur_q.hold, mem_rdata};
                end
                if (cur_q.step == LAST_POP_STEP) begin
                    nxt_d.mode = SEQ_IDLE;
                    nxt_d.step = '0;
                end
            end
            default: nxt_d.mode = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{mode: SEQ_IDLE, step: '0, ptr: '0, hold: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy     = (cur_q.mode != SEQ_IDLE);
    assign ld_a     = (tgt == REG_A);
    assign ld_x     = (tgt == REG_X);
    assign ld_b     = (tgt == REG_B);
    assign ld_sp    = (tgt == REG_SP);
    assign ld_pc    = (tgt == REG_PC);
    assign ld_flags = (tgt == REG_FLAGS);
endmodule

// File: rtl/trap_ctx_seq_chk.sv
module trap_ctx_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [7:0]  ir,
    input logic        rti_req,
    input logic        busy,
    input logic [15:0] mem_addr,
    input logic        mem_re,
    input logic        mem_we,
    input logic        ld_a,
    input logic        ld_x,
    input logic        ld_b,
    input logic        ld_sp,
    input logic        ld_pc,
    input logic        ld_flags
);
    localparam logic [4:0] LOWEST_TRAP = 5'b11101;

    a_r8_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r8_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_a, ld_x, ld_b, ld_sp, ld_pc, ld_flags}));

    a_r8_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a || ld_x || ld_b || ld_sp || ld_pc || ld_flags) |-> busy);

    a_r1_trap_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && (ir[7:3] >= LOWEST_TRAP)) |=> busy);

    a_r1_other_opc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && instr_valid && (ir[7:3] < LOWEST_TRAP) && !rti_req) |=> !busy);

    a_r3_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    a_r5_reads_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));
endmodule

bind trap_ctx_seq trap_ctx_seq_chk u_chk (.*);

// File: tb/trap_ctx_seq_tb.sv
module trap_ctx_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [7:0]  ir = 8'h00;
    logic        rti_req = 1'b0;
    logic        busy;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] r_a, r_x, r_b, r_sp, r_pc;
    logic [3:0]  r_f;
    logic        ld_a, ld_x, ld_b, ld_sp, ld_pc, ld_flags;
    logic [15:0] ld_word;

    logic [7:0]  mem [0:4095];
    logic        poke_en = 1'b0;
    logic [15:0] poke_addr = '0;
    logic [7:0]  poke_data = '0;
    logic        preset = 1'b0;
    logic [15:0] p_a, p_x, p_b, p_sp, p_pc;
    logic [3:0]  p_f;

    logic [23:0] exp_q [$];
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trap_ctx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ir(ir),
        .rti_req(rti_req), .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cur_a(r_a), .cur_x(r_x), .cur_b(r_b), .cur_sp(r_sp), .cur_pc(r_pc),
        .cur_flags(r_f), .ld_a(ld_a), .ld_x(ld_x), .ld_b(ld_b), .ld_sp(ld_sp),
        .ld_pc(ld_pc), .ld_flags(ld_flags), .ld_word(ld_word)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (poke_en) mem[poke_addr[11:0]] <= poke_data;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (preset) begin
            r_a <= p_a; r_x <= p_x; r_b <= p_b; r_sp <= p_sp; r_pc <= p_pc; r_f <= p_f;
        end else begin
            if (ld_a)     r_a  <= ld_word;
            if (ld_x)     r_x  <= ld_word;
            if (ld_b)     r_b  <= ld_word;
            if (ld_sp)    r_sp <= ld_word;
            if (ld_pc)    r_pc <= ld_word;
            if (ld_flags) r_f  <= ld_word[3:0];
        end
    end

    // Scoreboard monitor: every write must match the next expected frame byte (R3)
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nfail++;
                $display("FAIL R3 unexpected write actual=%h:%h expected=none",
                         mem_addr, mem_wdata);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_wdata} !== e) begin
                    nfail++;
                    $display("FAIL R3 frame byte actual=%h:%h expected=%h:%h",
                             mem_addr, mem_wdata, e[23:8], e[7:0]);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic set_regs(input logic [15:0] a, x, b, sp, pc, input logic [3:0] f);
        @(negedge clk);
        p_a = a; p_x = x; p_b = b; p_sp = sp; p_pc = pc; p_f = f; preset = 1'b1;
        @(negedge clk);
        preset = 1'b0;
    endtask

    task automatic chk_regs(input string tag, input logic [15:0] a, x, b, sp, pc,
                            input logic [3:0] f);
        chk({tag, " A"}, 32'(r_a), 32'(a));
        chk({tag, " X"}, 32'(r_x), 32'(x));
        chk({tag, " B"}, 32'(r_b), 32'(b));
        chk({tag, " SP"}, 32'(r_sp), 32'(sp));
        chk({tag, " PC"}, 32'(r_pc), 32'(pc));
        chk({tag, " flags"}, 32'(r_f), 32'(f));
    endtask

    // Driver: queues the expected frame, raises the trap, counts busy cycles
    task automatic run_entry(input logic [7:0] spec, input logic [15:0] base,
                             input logic [15:0] hand, input bit inject,
                             input bit with_rti);
        int n;
        logic [15:0] sa, sx, sb, ssp, spc;
        logic [3:0]  sf;
        poke(16'h0FFA, base[15:8]);
        poke(16'h0FFB, base[7:0]);
        poke(16'h0FFE, hand[15:8]);
        poke(16'h0FFF, hand[7:0]);
        sa = r_a; sx = r_x; sb = r_b; ssp = r_sp; spc = r_pc; sf = r_f;
        exp_q.push_back({base - 16'd1,  spec});
        exp_q.push_back({base - 16'd2,  ssp[7:0]});
        exp_q.push_back({base - 16'd3,  ssp[15:8]});
        exp_q.push_back({base - 16'd4,  spc[7:0]});
        exp_q.push_back({base - 16'd5,  spc[15:8]});
        exp_q.push_back({base - 16'd6,  sb[7:0]});
        exp_q.push_back({base - 16'd7,  sb[15:8]});
        exp_q.push_back({base - 16'd8,  sx[7:0]});
        exp_q.push_back({base - 16'd9,  sx[15:8]});
        exp_q.push_back({base - 16'd10, sa[7:0]});
        exp_q.push_back({base - 16'd11, sa[15:8]});
        exp_q.push_back({base - 16'd12, {4'h0, sf}});
        @(negedge clk);
        instr_valid = 1'b1; ir = spec; rti_req = with_rti;
        @(negedge clk);
        instr_valid = 1'b0; rti_req = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            n++;
            if (inject && n == 3) begin instr_valid = 1'b1; rti_req = 1'b1; end
            if (inject && n == 7) begin instr_valid = 1'b0; rti_req = 1'b0; end
            @(negedge clk);
        end
        chk("R4 entry busy cycles", 32'(n), 32'd16);
        chk("R3 frame fully written", 32'(exp_q.size()), 32'd0);
        chk_regs("R4 after entry", sa, sx, sb, base - 16'd12, hand, sf);
        @(negedge clk);
        chk("R7 busy low after sequence", 32'(busy), 32'd0);
        exp_q.delete();
    endtask

    task automatic run_return(input logic [15:0] a, x, b, sp, pc, input logic [3:0] f,
                              input string tag);
        int n;
        @(negedge clk);
        rti_req = 1'b1;
        @(negedge clk);
        rti_req = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk("R5 return busy cycles", 32'(n), 32'd11);
        chk_regs(tag, a, x, b, sp, pc, f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R4 watchdog actual=hung expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset busy", 32'(busy), 32'd0);
        chk("R8 reset write strobe", 32'(mem_we), 32'd0);
        chk("R8 reset read strobe", 32'(mem_re), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle loads", 32'({ld_a, ld_x, ld_b, ld_sp, ld_pc, ld_flags}), 32'd0);

        // R1, R2, R3, R4, R6: opcode 11101, untouched frame round trip
        set_regs(16'h1234, 16'h5678, 16'h9ABC, 16'h0C40, 16'h0123, 4'hA);
        run_entry(8'hE8, 16'h0E00, 16'h0A00, 1'b0, 1'b0);
        run_return(16'h1234, 16'h5678, 16'h9ABC, 16'h0C40, 16'h0123, 4'hA, "R6 round trip");

        // R7: requests injected mid-entry, opcode 11111
        set_regs(16'hFFFF, 16'h0001, 16'h8000, 16'h0BFE, 16'hFFFE, 4'h5);
        run_entry(8'hFF, 16'h0D10, 16'h0B20, 1'b1, 1'b0);
        run_return(16'hFFFF, 16'h0001, 16'h8000, 16'h0BFE, 16'hFFFE, 4'h5, "R6 second round trip");

        // R7 priority, R5 values from memory: opcode 11110 with rti_req together
        set_regs(16'h0F0F, 16'hA5A5, 16'h3C3C, 16'h0700, 16'h4444, 4'h3);
        run_entry(8'hF3, 16'h0E80, 16'h0C00, 1'b0, 1'b1);
        poke(16'h0E80 - 16'd12 + 16'd7, 8'h56);   // saved PC high byte
        poke(16'h0E80 - 16'd12 + 16'd8, 8'h78);   // saved PC low byte
        poke(16'h0E80 - 16'd12 + 16'd0, 8'hF9);   // saved flags, only bits 3:0 load
        poke(16'h0E80 - 16'd12 + 16'd11, 8'h00);  // spec slot, never loaded
        run_return(16'h0F0F, 16'hA5A5, 16'h3C3C, 16'h0700, 16'h5678, 4'h9, "R5 edited frame");

        // R1: neighbouring and ordinary opcodes leave the block idle
        for (int k = 0; k < 3; k++) begin
            logic [7:0] op;
            op = (k == 0) ? 8'hE7 : (k == 1) ? 8'h00 : 8'h68;
            @(negedge clk);
            instr_valid = 1'b1; ir = op;
            @(negedge clk);
            instr_valid = 1'b0;
            chk("R1 non-trap opcode busy", 32'(busy), 32'd0);
            @(negedge clk);
            chk_regs("R1 non-trap regs", 16'h0F0F, 16'hA5A5, 16'h3C3C, 16'h0700, 16'h5678, 4'h9);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule